// File: doc/BRIEF.md
# CAN Bit Timing Generator with Bus Sampler

This block derives the bit timing of a CAN receiver from the system clock and turns the received bus line into one sampled bit value per bit time. A programmable divider produces time quanta. Each bit time is laid out as one synchronisation quantum, then a first timing segment, then a second timing segment. At the end of the first segment, which is the sample point, the block either takes the bus value as it is or takes the majority of three readings gathered on the last three quantum boundaries.

The divider and segment settings sit in two 8-bit configuration words behind a small read/write port. Both words can be read at any time. They change only while the controller is in initialization mode, meaning initialization is requested and acknowledged at once. While in that mode the quantum and bit counters are held in their reset state, so a new setting always starts from a clean bit boundary. The surrounding controller uses the one-clock bit-start strobe, the one-clock sample strobe and the registered sampled bit to drive its frame logic.

Top module: `can_bit_timer`

## Requirements
- R1: After reset both configuration words read 0, `rx_bit` is 1, and `bit_start` and `sample_strobe` stay 0 while reset is asserted. `rx_bit` changes only in the clock after a `sample_strobe` pulse.
- R2: A time quantum lasts P+1 clocks, where P is bits [5:0] of the divider word (address 0), so one bit time lasts (P+1)*(T1+T2+3) clocks. T1 is bits [3:0] and T2 is bits [6:4] of the timing word (address 1).
- R3: `rd_data` shows the word chosen by `rd_addr` in the same cycle: address 0 gives the divider in bits [5:0] with bits [7:6] reading 0, and address 1 gives the timing word with the mode bit in bit 7, T2 in bits [6:4] and T1 in bits [3:0].
- R4: A write (`wr_en` high at a rising edge) updates the addressed word only when `init_req` and `init_ack` are both 1. Otherwise it has no effect.
- R5: The sync quantum is quantum 0, the first segment spans quanta 1 to T1+1 and the second spans the T2+1 quanta after that. `sample_strobe` is high for exactly the last clock of quantum T1+1.
- R6: `bit_start` is high for exactly the first clock of every sync quantum, including the first clock after initialization mode ends.
- R7: With the mode bit at 0, the `rx_bit` presented after a sample strobe equals `rx` in the strobe clock.
- R8: With the mode bit at 1, `rx_bit` takes the majority of `rx` in the strobe clock and `rx` in the last clock of each of the two quanta before it.
- R9: `cfg_err` is 1 exactly when the mode bit is 1 and T1 is 0, which is when the first segment holds fewer than 2 quanta.
- R10: While `init_req` and `init_ack` are both 1, neither strobe fires and the counters restart from the sync quantum when the mode ends. `rx_bit` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| wr_en | input | 1 | Configuration write enable |
| wr_addr | input | 1 | Write target: 0 divider, 1 timing word |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 divider, 1 timing word |
| rd_data | output | 8 | Selected configuration word |
| rx | input | 1 | Received bus line, already synchronised to clk |
| bit_start | output | 1 | One-clock pulse at the start of each sync quantum |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| rx_bit | output | 1 | Sampled bit value, registered |
| cfg_err | output | 1 | Majority mode selected with too short a first segment |

## Verification
On every cycle the bound checker confirms that both strobes stay quiet in initialization mode and never coincide. It also confirms that a bit-start pulse lasts one clock, that the configuration words hold outside initialization mode, and that the sampled bit moves only after a sample strobe and copies the bus in single-sample mode. Only the bench's scenarios can show that bit periods and sample-point positions follow the divider and segment fields over their full ranges, including a divider of 64 and the longest segments. The same applies to the majority vote rejecting one-quantum glitches on a pseudo-random bus, and to counting restarting cleanly after initialization mode and after reset.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   // configuration word width on the register port
   localparam int unsigned CFG_W      = 8;

   // timing word field layout (decoded by the bit sequencer and sampler)
   localparam int unsigned MODE_BIT   = 7;
   localparam int unsigned SEG2_LSB   = 4;
   localparam int unsigned SEG2_W     = 3;
   localparam int unsigned SEG1_LSB   = 0;
   localparam int unsigned SEG1_W     = 4;

   // register addresses
   localparam logic ADDR_DIV    = 1'b0;
   localparam logic ADDR_TIMING = 1'b1;

   typedef struct packed {
      logic              triple;
      logic [SEG2_W-1:0] seg2;
      logic [SEG1_W-1:0] seg1;
   } timing_word_t;

endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
   import can_bt_pkg::*;
#(
   parameter int unsigned DIV_W     = 6,
   parameter bit          TRIPLE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_open,
   input  logic                 wr_en,
   input  logic                 wr_addr,
   input  logic [CFG_W-1:0]     wr_data,
   input  logic                 rd_addr,
   output logic [CFG_W-1:0]     rd_data,
   output logic [DIV_W-1:0]     div_q,
   output timing_word_t         timing_q,
   output logic                 cfg_err
);

   logic         wr_div;
   logic         wr_tim;
   timing_word_t timing_d;

   assign wr_div = wr_en & cfg_open & (wr_addr == ADDR_DIV);
   assign wr_tim = wr_en & cfg_open & (wr_addr == ADDR_TIMING);

   generate
      if (TRIPLE_EN) begin : g_mode_kept
         always_comb begin
            timing_d = timing_word_t'(wr_data);
         end
      end else begin : g_mode_tied
         always_comb begin
            timing_d        = timing_word_t'(wr_data);
            timing_d.triple = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (wr_div) begin
         div_q <= wr_data[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing_q <= '0;
      end else if (wr_tim) begin
         timing_q <= timing_d;
      end
   end

   always_comb begin
      if (rd_addr == ADDR_TIMING) begin
         rd_data = CFG_W'(timing_q);
      end else begin
         rd_data = CFG_W'(div_q);
      end
   end

   assign cfg_err = timing_q.triple & (timing_q.seg1 == '0);

endmodule

// File: rtl/cbt_tq_gen.sv
module cbt_tq_gen #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tq_tick,
   output logic             tq_first
);

   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // last clock of a quantum
   assign tq_tick  = run & at_end;
   // first clock of a quantum
   assign tq_first = run & (cnt_q == '0);

endmodule

// File: rtl/cbt_bit_seq.sv
module cbt_bit_seq
   import can_bt_pkg::*;
#(
   parameter int unsigned QC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tq_tick,
   input  logic              tq_first,
   input  logic [SEG1_W-1:0] seg1,
   input  logic [SEG2_W-1:0] seg2,
   output logic              bit_start,
   output logic              sample_pt
);

   logic [QC_W-1:0] qc_q;
   logic [QC_W-1:0] last_q;
   logic [QC_W-1:0] sample_q;

   // quanta: 0 sync, 1..seg1+1 first segment, then seg2+1 quanta
   assign last_q   = QC_W'(seg1) + QC_W'(seg2) + QC_W'(2);
   assign sample_q = QC_W'(seg1) + QC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qc_q <= '0;
      end else if (!run) begin
         qc_q <= '0;
      end else if (tq_tick) begin
         if (qc_q == last_q) begin
            qc_q <= '0;
         end else begin
            qc_q <= qc_q + 1'b1;
         end
      end
   end

   assign bit_start = run & tq_first & (qc_q == '0);
   assign sample_pt = tq_tick & (qc_q == sample_q);

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
   parameter bit TRIPLE_EN = 1'b1,
   parameter bit IDLE_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tq_tick,
   input  logic sample_pt,
   input  logic triple,
   input  logic rx,
   output logic rx_bit
);

   logic bit_d;

   generate
      if (TRIPLE_EN) begin : g_vote
         // hist_q[0]: previous quantum boundary, hist_q[1]: the one before
         logic [1:0] hist_q;
         logic       vote;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= {2{IDLE_VAL}};
            end else if (!run) begin
               hist_q <= {2{IDLE_VAL}};
            end else if (tq_tick) begin
               hist_q <= {hist_q[0], rx};
            end
         end

         assign vote  = (rx & hist_q[0]) | (rx & hist_q[1]) | (hist_q[0] & hist_q[1]);
         assign bit_d = triple ? vote : rx;
      end else begin : g_single
         logic unused_mode;
         assign unused_mode = triple & run & tq_tick;
         assign bit_d       = rx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_bit <= IDLE_VAL;
      end else if (sample_pt) begin
         rx_bit <= bit_d;
      end
   end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
   import can_bt_pkg::*;
#(
   parameter int unsigned DIV_W     = 6,
   parameter bit          TRIPLE_EN = 1'b1,
   parameter bit          IDLE_VAL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_req,
   input  logic             init_ack,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             rd_addr,
   output logic [CFG_W-1:0] rd_data,
   input  logic             rx,
   output logic             bit_start,
   output logic             sample_strobe,
   output logic             rx_bit,
   output logic             cfg_err
);

   localparam int unsigned MAX_QUANTA = (1 << SEG1_W) + (1 << SEG2_W) + 1;
   localparam int unsigned QC_W       = $clog2(MAX_QUANTA + 1);

   generate
      if (DIV_W < 1 || DIV_W > CFG_W) begin : g_bad_div_w
         $error("DIV_W must lie between 1 and the configuration word width");
      end
      if (SEG1_W + SEG2_W + 1 > CFG_W) begin : g_bad_layout
         $error("timing fields do not fit in one configuration word");
      end
   endgenerate

   logic             cfg_open;
   logic             run;
   logic [DIV_W-1:0] div_q;
   timing_word_t     timing_q;
   logic             tq_tick;
   logic             tq_first;
   logic             sample_pt;

   assign cfg_open = init_req & init_ack;
   assign run      = rst_n & ~cfg_open;

   cbt_cfg_regs #(
      .DIV_W     (DIV_W),
      .TRIPLE_EN (TRIPLE_EN)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_open (cfg_open),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .div_q    (div_q),
      .timing_q (timing_q),
      .cfg_err  (cfg_err)
   );

   cbt_tq_gen #(
      .DIV_W (DIV_W)
   ) u_tq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div      (div_q),
      .tq_tick  (tq_tick),
      .tq_first (tq_first)
   );

   cbt_bit_seq #(
      .QC_W (QC_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tq_tick   (tq_tick),
      .tq_first  (tq_first),
      .seg1      (timing_q.seg1),
      .seg2      (timing_q.seg2),
      .bit_start (bit_start),
      .sample_pt (sample_pt)
   );

   cbt_sampler #(
      .TRIPLE_EN (TRIPLE_EN),
      .IDLE_VAL  (IDLE_VAL)
   ) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tq_tick   (tq_tick),
      .sample_pt (sample_pt),
      .triple    (timing_q.triple),
      .rx        (rx),
      .rx_bit    (rx_bit)
   );

   assign sample_strobe = sample_pt;

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
   parameter int unsigned DIV_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             init_req,
   input logic             init_ack,
   input logic             rx,
   input logic             bit_start,
   input logic             sample_strobe,
   input logic             rx_bit,
   input logic             cfg_err,
   input logic [DIV_W-1:0] div_q,
   input logic [7:0]       timing_bits
);

   // R10
   init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req && init_ack) |-> (!bit_start && !sample_strobe));

   // R5
   strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> !bit_start);

   // R6
   bit_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start |=> !bit_start);

   // R7
   single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_strobe && !timing_bits[7]) |=> (rx_bit == $past(rx)));

   // R1
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_strobe |=> $stable(rx_bit));

   // R4
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_req && init_ack) |=> ($stable(timing_bits) && $stable(div_q)));

   // R9
   err_needs_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> timing_bits[7]);

endmodule

bind can_bit_timer can_bit_timer_chk #(
   .DIV_W (DIV_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .init_req      (init_req),
   .init_ack      (init_ack),
   .rx            (rx),
   .bit_start     (bit_start),
   .sample_strobe (sample_strobe),
   .rx_bit        (rx_bit),
   .cfg_err       (cfg_err),
   .div_q         (div_q),
   .timing_bits   (timing_q)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_req = 1'b0;
   logic       init_ack = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       rx = 1'b1;
   logic       bit_start;
   logic       sample_strobe;
   logic       rx_bit;
   logic       cfg_err;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   bit  rd_auto = 1'b1;
   logic rd_sel = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // reference model state
   int  m_div = 0;
   int  m_tim = 0;
   int  m_pos = 0;
   int  m_bit = 1;
   int  m_h0 = 1;
   int  m_h1 = 1;
   longint cyc = 0;
   longint last_bs = -1;
   longint bs_period = 0;

   always #4 clk = ~clk;

   can_bit_timer uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .init_req      (init_req),
      .init_ack      (init_ack),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data),
      .rx            (rx),
      .bit_start     (bit_start),
      .sample_strobe (sample_strobe),
      .rx_bit        (rx_bit),
      .cfg_err       (cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // bus and read-select stimulus, changed away from the rising edge
   always @(negedge clk) begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx      <= lfsr[0] ^ (lfsr[5] & lfsr[9]);
      rd_addr <= rd_auto ? ~rd_addr : rd_sel;
   end

   // cycle-by-cycle reference model, compared late in each cycle
   always @(posedge clk) begin
      int q, nq, t1, t2, md, qi, vote, exp_bs, exp_ss, exp_rd;
      bit run, tick;
      #6;
      cyc++;
      if (!rst_n) begin
         m_div = 0; m_tim = 0; m_pos = 0; m_bit = 1; m_h0 = 1; m_h1 = 1;
      end
      run = rst_n && !(init_req && init_ack);
      t1 = m_tim & 15;
      t2 = (m_tim >> 4) & 7;
      md = (m_tim >> 7) & 1;
      q  = m_div + 1;
      nq = t1 + t2 + 3;
      tick = run && ((m_pos % q) == q - 1);
      qi = m_pos / q;
      exp_bs = (run && m_pos == 0) ? 1 : 0;
      exp_ss = (tick && qi == t1 + 1) ? 1 : 0;
      exp_rd = rd_addr ? m_tim : m_div;

      chk(!rst_n ? "R1 bit_start" : (!run ? "R10 bit_start" : "R6 bit_start"),
          int'(bit_start), exp_bs);
      chk(!rst_n ? "R1 sample_strobe" : (!run ? "R10 sample_strobe" : "R5 sample_strobe"),
          int'(sample_strobe), exp_ss);
      chk(md ? "R8 rx_bit" : "R7 rx_bit", int'(rx_bit), m_bit);
      chk("R9 cfg_err", int'(cfg_err), (md == 1 && t1 == 0) ? 1 : 0);
      chk("R3 rd_data", int'(rd_data), exp_rd);

      if (bit_start) begin
         if (last_bs >= 0) bs_period = cyc - last_bs;
         last_bs = cyc;
      end
      if (!run) begin
         last_bs = -1;
      end

      if (rst_n) begin
         if (run) begin
            if (exp_ss == 1) begin
               vote = (int'(rx) + m_h0 + m_h1 >= 2) ? 1 : 0;
               m_bit = md ? vote : int'(rx);
            end
            if (tick) begin
               m_h1 = m_h0;
               m_h0 = int'(rx);
            end
            m_pos = (m_pos + 1) % (q * nq);
         end else begin
            m_pos = 0; m_h0 = 1; m_h1 = 1;
         end
         if (wr_en && init_req && init_ack) begin
            if (wr_addr) m_tim = int'(wr_data);
            else         m_div = int'(wr_data[5:0]);
         end
      end
   end

   task automatic cfg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic enter_init();
      @(negedge clk); init_req = 1'b1;
      @(negedge clk); init_ack = 1'b1;
   endtask

   task automatic leave_init();
      @(negedge clk); init_ack = 1'b0; init_req = 1'b0;
   endtask

   task automatic configure(input int dv, input int md, input int t2, input int t1);
      enter_init();
      cfg_write(1'b0, 8'(dv));
      cfg_write(1'b1, 8'((md << 7) | (t2 << 4) | t1));
      repeat (5) @(negedge clk);
      leave_init();
   endtask

   task automatic read_word(input logic a, output int v);
      rd_auto = 1'b0; rd_sel = a;
      @(negedge clk); @(negedge clk);
      #1 v = int'(rd_data);
      rd_auto = 1'b1;
   endtask

   initial begin
      int v;
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk("R1 rx_bit at reset", int'(rx_bit), 1);
      chk("R1 strobes at reset", int'(bit_start | sample_strobe), 0);
      read_word(1'b1, v);
      chk("R1 timing word at reset", v, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // single sampling, divider 1
      configure(0, 0, 2, 3);
      repeat (80) @(negedge clk);
      chk("R2 bit period div=1", int'(bs_period), 1 * (3 + 2 + 3));

      // R4: writes outside init mode are ignored
      cfg_write(1'b1, 8'hFF);
      cfg_write(1'b0, 8'h3F);
      read_word(1'b1, v);
      chk("R4 timing word after locked write", v, 8'h23);
      read_word(1'b0, v);
      chk("R4 divider after locked write", v, 0);
      @(negedge clk); init_req = 1'b1;
      cfg_write(1'b1, 8'h80);
      @(negedge clk); init_req = 1'b0;
      read_word(1'b1, v);
      chk("R4 timing word with request only", v, 8'h23);
      init_ack = 1'b1;
      cfg_write(1'b1, 8'h80);
      @(negedge clk); init_ack = 1'b0;
      read_word(1'b1, v);
      chk("R4 timing word with ack only", v, 8'h23);

      // majority sampling, divider 3
      configure(2, 1, 1, 4);
      repeat (300) @(negedge clk);
      chk("R2 bit period div=3", int'(bs_period), 3 * (4 + 1 + 3));

      // configuration error case
      configure(0, 1, 0, 0);
      #1 chk("R9 error flag", int'(cfg_err), 1);
      repeat (60) @(negedge clk);

      // longest segments, divider 64
      configure(63, 1, 7, 15);
      repeat (3400) @(negedge clk);
      chk("R2 bit period div=64", int'(bs_period), 64 * (15 + 7 + 3));

      // shortest bit, majority with T1 = 1
      configure(1, 1, 0, 1);
      repeat (200) @(negedge clk);
      chk("R2 bit period div=2", int'(bs_period), 2 * (1 + 0 + 3));

      // R10: init hold mid-bit, then clean restart
      repeat (3) @(negedge clk);
      enter_init();
      repeat (25) @(negedge clk);
      leave_init();
      repeat (100) @(negedge clk);

      // reset in the middle of operation
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      read_word(1'b0, v);
      chk("R1 divider after reset", v, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (40) @(negedge clk);

      finish_run();
   end

   initial begin
      #(8 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule